// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Controller

This block is the device side of a three-wire serial EEPROM holding 1024 words of 16 bits. A host raises chip select and clocks command frames in on the serial data input, one bit per serial-clock rising edge. The block finds the start bit and decodes three commands. The first reads words out continuously. The second programs a single word. The third fills one 128-word block with a single value. Read data and program status come back on a serial output that has a separate output-enable, so the output can be tri-stated.

All three host inputs pass through a two-flop synchroniser into the system clock domain, and the block detects edges on the synchronised copies. The word array is a register array. Programming is modelled as a busy period of `PROG_CYCLES` system clocks. The array is updated when the busy period starts. The busy period only governs status and whether commands are accepted.

Frame layout, first bit first: a start bit of 1, then two opcode bits, then ten address bits sent most significant first. A write frame ends with sixteen data bits, also most significant first. The opcodes are 10 for read, 01 for word write and 00 for block fill. Counting the start bit as SK rise 1, the last data bit of a write is taken on SK rise 29.

Top module: `mw_eeprom_slave`

## Requirements
- R1: While chip select is high, any 0s sampled on the data input before the first 1 are ignored. The first 1 begins a frame.
- R2: In a read frame (opcode 10), the SK rise after the last address bit drives the output enabled with a single 0. The next 16 rises present the addressed word, most significant bit first.
- R3: If SK keeps toggling with chip select high after a read word, the block presents the following address's word with no new frame. Address 1023 is followed by address 0.
- R4: A word write (opcode 01) stores its 16 data bits at its address only if chip select falls after SK rise 29 and before SK rise 30. If the chip-select fall and SK rise 30 reach the synchroniser in the same system cycle, the write still happens.
- R5: If SK rise 30 arrives while chip select is still high, the write is dropped and no storage changes.
- R6: A block fill (opcode 00) takes the top three address bits as the block number. When it commits under the R4 window rule, all 128 words of that block take the data word and all other words keep their values.
- R7: A committed write or fill starts a busy period of `PROG_CYCLES` cycles. If chip select is raised during that period, the output is enabled and shows 0 while busy and 1 once ready, until chip select falls.
- R8: A frame sent while the busy period runs changes no storage.
- R9: The output enable is low whenever chip select is low and no read or status is being driven. A frame cut short by chip select falling early writes nothing.
- R10: Opcode 11 is not a command. Its frame writes nothing and starts no busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select, active high, asynchronous to clk |
| sk | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data in |
| dout | output | 1 | Serial data out, valid while dout_oe is high |
| dout_oe | output | 1 | Output enable for dout; low means high impedance |

## Verification
Two events can land in the same system cycle: the chip-select fall that commits a write, and SK rise 30, which would cancel it. The bench provokes this by driving both pins on the same bench edge after the 29th clock. It then reads the address back and expects the new word, because the fall takes priority. Separately, it checks the clean commit case, and the cancel case where a full extra SK rise comes before chip select falls and the old word must remain.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_DATA,
        ST_COMMIT,
        ST_RDUMMY,
        ST_RDATA,
        ST_HOLD
    } mw_state_e;

    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_FILL  = 2'b00;
    localparam logic [1:0] OPC_NONE  = 2'b11;

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] level_o
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        logic [STAGES-1:0] chain_d;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= chain_d;
        end

        assign level_o[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)            cnt_d = CW'(CYCLES);
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/mw_array.sv
module mw_array #(
    parameter int AW = 10,
    parameter int DW = 16,
    parameter int BW = 3
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic          fill_en,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;
    localparam int SHIFT = AW - BW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if ((wr_en && (waddr == AW'(i))) ||
                (fill_en && (waddr[AW-1 -: BW] == BW'(i >> SHIFT)))) begin
                mem[i] <= wdata;
            end
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave
    import mw_pkg::*;
#(
    parameter int AW          = 10,
    parameter int DW          = 16,
    parameter int BW          = 3,
    parameter int PROG_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sk,
    input  logic di,
    output logic dout,
    output logic dout_oe
);

    localparam int MAXW  = (AW > DW) ? AW : DW;
    localparam int CNT_W = $clog2(MAXW);

    typedef struct packed {
        mw_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic [1:0]       opc;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    data;
        logic             dout;
        logic             oe;
        logic             status;
        logic             cs_p;
        logic             sk_p;
    } regs_t;

    regs_t q, d;

    logic [2:0]    lvl;
    logic          cs_s, sk_s, di_s;
    logic          cs_rise, sk_rise;
    logic          busy;
    logic          prog_start, wr_en, fill_en;
    logic [DW-1:0] rdata;

    mw_sync #(.W(3), .STAGES(2)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs, sk, di}),
        .level_o (lvl)
    );

    assign cs_s    = lvl[2];
    assign sk_s    = lvl[1];
    assign di_s    = lvl[0];
    assign cs_rise = cs_s & ~q.cs_p;
    assign sk_rise = sk_s & ~q.sk_p;

    mw_prog_timer #(.CYCLES(PROG_CYCLES)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (prog_start),
        .busy_o  (busy)
    );

    mw_array #(.AW(AW), .DW(DW), .BW(BW)) i_array (
        .clk     (clk),
        .wr_en   (wr_en),
        .fill_en (fill_en),
        .waddr   (q.addr),
        .wdata   (q.data),
        .raddr   (q.addr),
        .rdata   (rdata)
    );

    always_comb begin
        d          = q;
        d.cs_p     = cs_s;
        d.sk_p     = sk_s;
        prog_start = 1'b0;
        wr_en      = 1'b0;
        fill_en    = 1'b0;

        if (!cs_s) begin
            // a fall inside the window commits; any other fall discards
            if (q.st == ST_COMMIT) begin
                prog_start = 1'b1;
                wr_en      = (q.opc == OPC_WRITE);
                fill_en    = (q.opc == OPC_FILL);
            end
            d.st     = ST_IDLE;
            d.cnt    = '0;
            d.oe     = 1'b0;
            d.dout   = 1'b0;
            d.status = 1'b0;
        end else begin
            d.status = q.status | (cs_rise & busy);
            if (d.status) begin
                d.oe   = 1'b1;
                d.dout = ~busy;
            end else if (sk_rise) begin
                unique case (q.st)
                    ST_IDLE: begin
                        if (di_s) begin
                            d.st  = ST_OPC;
                            d.cnt = '0;
                        end
                    end
                    ST_OPC: begin
                        d.opc = {q.opc[0], di_s};
                        if (q.cnt == CNT_W'(1)) begin
                            d.cnt = '0;
                            d.st  = ({q.opc[0], di_s} == OPC_NONE) ? ST_HOLD : ST_ADDR;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                    ST_ADDR: begin
                        d.addr = {q.addr[AW-2:0], di_s};
                        if (q.cnt == CNT_W'(AW - 1)) begin
                            d.cnt = '0;
                            d.st  = (q.opc == OPC_READ) ? ST_RDUMMY : ST_DATA;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        d.data = {q.data[DW-2:0], di_s};
                        if (q.cnt == CNT_W'(DW - 1)) d.st = ST_COMMIT;
                        else                         d.cnt = q.cnt + 1'b1;
                    end
                    ST_COMMIT: begin
                        d.st = ST_HOLD;
                    end
                    ST_RDUMMY: begin
                        d.oe   = 1'b1;
                        d.dout = 1'b0;
                        d.cnt  = CNT_W'(DW - 1);
                        d.st   = ST_RDATA;
                    end
                    ST_RDATA: begin
                        d.dout = rdata[q.cnt];
                        if (q.cnt == '0) begin
                            d.cnt  = CNT_W'(DW - 1);
                            d.addr = q.addr + 1'b1;
                        end else begin
                            d.cnt = q.cnt - 1'b1;
                        end
                    end
                    default: begin
                        d.st = ST_HOLD;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dout    = q.dout;
    assign dout_oe = q.oe;

endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk
    import mw_pkg::*;
#(
    parameter int AW    = 10,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_s,
    input logic             sk_rise,
    input mw_state_e        st,
    input logic [CNT_W-1:0] cnt,
    input logic [AW-1:0]    addr,
    input logic             status,
    input logic             busy,
    input logic             prog_start,
    input logic             wr_en,
    input logic             fill_en,
    input logic             dout,
    input logic             dout_oe
);

    p_dummy_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && sk_rise && st == ST_RDUMMY) |=> (dout_oe && !dout));

    p_addr_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && sk_rise && !status && st == ST_RDATA && cnt == '0 && addr == '1)
        |=> (addr == '0));

    p_late_cancel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && sk_rise && st == ST_COMMIT) |=> (st == ST_HOLD && !busy));

    p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> busy);

    p_status_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        status |-> (dout_oe && (dout == !$past(busy))));

    p_no_write_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!wr_en && !fill_en));

    p_hiz_cs_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> !dout_oe);

endmodule

bind mw_eeprom_slave mw_eeprom_chk #(.AW(AW), .CNT_W(CNT_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_s       (cs_s),
    .sk_rise    (sk_rise),
    .st         (q.st),
    .cnt        (q.cnt),
    .addr       (q.addr),
    .status     (q.status),
    .busy       (busy),
    .prog_start (prog_start),
    .wr_en      (wr_en),
    .fill_en    (fill_en),
    .dout       (dout),
    .dout_oe    (dout_oe)
);

// File: tb/test_mw_eeprom_slave.sv
module test_mw_eeprom_slave;

    localparam int PROG = 200;
    localparam int HP   = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0;
    logic sk = 1'b0;
    logic di = 1'b0;
    logic dout, dout_oe;

    int total = 0;
    int bad   = 0;

    logic [15:0] model [1024];

    always #4 clk = ~clk;

    mw_eeprom_slave #(.AW(10), .DW(16), .BW(3), .PROG_CYCLES(PROG)) i_mw_eeprom_slave (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs      (cs),
        .sk      (sk),
        .di      (di),
        .dout    (dout),
        .dout_oe (dout_oe)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic b);
        di = b;
        wait_n(HP);
        sk = 1'b1;
        wait_n(HP);
        sk = 1'b0;
    endtask

    task automatic pulse_rd(output logic o, output logic oe);
        di = 1'b0;
        wait_n(HP);
        sk = 1'b1;
        wait_n(HP);
        o  = dout;
        oe = dout_oe;
        sk = 1'b0;
    endtask

    task automatic send(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) pulse(v[i]);
    endtask

    // R1: random count of leading zeros ahead of the start bit
    task automatic frame_head(input logic [1:0] opc, input logic [9:0] a);
        int z;
        @(negedge clk);
        cs = 1'b1;
        wait_n(HP);
        z = int'($urandom_range(0, 3));
        for (int i = 0; i < z; i++) pulse(1'b0);
        pulse(1'b1);
        send({30'd0, opc}, 2);
        send({22'd0, a}, 10);
    endtask

    task automatic cs_low();
        cs = 1'b0;
        di = 1'b0;
        wait_n(HP);
    endtask

    // mode 0: commit, 1: late (cancel), 2: same-edge fall
    task automatic do_write(input logic [1:0] opc, input logic [9:0] a, input logic [15:0] v, input int mode);
        frame_head(opc, a);
        send({16'd0, v}, 16);
        if (mode == 1) begin
            pulse(1'b0);
            cs_low();
        end else if (mode == 2) begin
            wait_n(HP);
            sk = 1'b1;
            cs = 1'b0;
            wait_n(HP);
            sk = 1'b0;
            wait_n(HP);
        end else begin
            wait_n(HP);
            cs_low();
        end
    endtask

    task automatic model_fill(input logic [2:0] blk, input logic [15:0] v);
        for (int i = 0; i < 128; i++) model[{blk, 7'(i)}] = v;
    endtask

    task automatic read_check(input logic [9:0] a, input int nw, input string req);
        logic o, oe;
        logic [15:0] w;
        logic [9:0]  ca;
        frame_head(2'b10, a);
        pulse_rd(o, oe);
        chk(oe === 1'b1 && o === 1'b0, "R2 dummy bit", {30'd0, oe, o}, 32'h2);
        ca = a;
        for (int k = 0; k < nw; k++) begin
            for (int b = 15; b >= 0; b--) begin
                pulse_rd(o, oe);
                w[b] = o;
            end
            chk(w === model[ca], req, {22'd0, ca} << 16 | {16'd0, w}, {22'd0, ca} << 16 | {16'd0, model[ca]});
            ca = ca + 10'd1;
        end
        cs_low();
    endtask

    task automatic wait_ready();
        wait_n(PROG + 20);
    endtask

    initial begin
        void'($urandom(32'd1234));
        wait_n(5);
        chk(dout_oe === 1'b0, "R9 reset output disabled", {31'd0, dout_oe}, 0);
        rst_n = 1'b1;
        wait_n(5);

        // R6: fill every block with its own value
        for (int b = 0; b < 8; b++) begin
            logic [15:0] v;
            v = 16'hA000 + 16'(b * 16'h0111);
            do_write(2'b00, {3'(b), 7'($urandom_range(0, 127))}, v, 0);
            model_fill(3'(b), v);
            wait_ready();
        end
        read_check(10'd126, 4, "R6 fill across block edge");
        read_check(10'd895, 2, "R6 fill top blocks");
        do_write(2'b00, {3'd5, 7'd3}, 16'h5A5A, 0);
        model_fill(3'd5, 16'h5A5A);
        wait_ready();
        read_check(10'd639, 3, "R6 refill block 5 only");

        // R3: wrap
        do_write(2'b01, 10'd1023, 16'hBEEF, 0);
        model[1023] = 16'hBEEF;
        wait_ready();
        read_check(10'd1023, 2, "R3 wrap 1023 to 0");

        // R7 status while busy and ready
        begin
            logic o, oe;
            do_write(2'b01, 10'd300, 16'h1357, 0);
            model[300] = 16'h1357;
            @(negedge clk);
            cs = 1'b1;
            wait_n(HP);
            chk(dout_oe === 1'b1 && dout === 1'b0, "R7 busy status", {30'd0, dout_oe, dout}, 32'h2);
            // R8: a frame sent while busy is ignored
            send({31'd0, 1'b1}, 1);
            send(32'h1, 2);
            send(32'd301, 10);
            send(32'hDEAD, 16);
            wait_n(PROG);
            chk(dout_oe === 1'b1 && dout === 1'b1, "R7 ready status", {30'd0, dout_oe, dout}, 32'h3);
            cs_low();
            o = dout; oe = dout_oe;
            chk(oe === 1'b0, "R9 released after status", {31'd0, oe}, 0);
            read_check(10'd300, 2, "R8 busy frame ignored / R4 word");
        end

        // R4 same-edge commit, R5 late cancel
        do_write(2'b01, 10'd40, 16'hC0DE, 2);
        model[40] = 16'hC0DE;
        wait_ready();
        read_check(10'd40, 1, "R4 same-cycle commit");
        do_write(2'b01, 10'd41, 16'h0BAD, 1);
        wait_ready();
        read_check(10'd41, 1, "R5 late fall cancels");

        // R9: cut frame, R10: opcode 11
        frame_head(2'b01, 10'd42);
        send(32'hFFF, 12);
        cs_low();
        wait_ready();
        read_check(10'd42, 1, "R9 partial frame discarded");
        do_write(2'b11, 10'd43, 16'h7777, 0);
        @(negedge clk);
        cs = 1'b1;
        wait_n(HP);
        chk(dout_oe === 1'b0, "R10 no busy after opcode 11", {31'd0, dout_oe}, 0);
        cs_low();
        read_check(10'd43, 1, "R10 opcode 11 writes nothing");

        // random writes and reads
        for (int it = 0; it < 30; it++) begin
            logic [9:0]  a;
            logic [15:0] v;
            a = 10'($urandom_range(0, 1023));
            v = 16'($urandom);
            do_write(2'b01, a, v, 0);
            model[a] = v;
            wait_ready();
            read_check(a, 1 + int'($urandom_range(0, 1)), "R4 random write readback");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule